// File: doc/BRIEF.md
# Dual-Quadruplet Majority Pad Coincidence Trigger

This block turns per-layer pad hit bits into a trigger decision for one sector. The sector has eight pad layers in two groups of four. Within a group, each layer's pad grid is shifted by half a pad in x, in y, or in both. The overlap of the shifted pad edges cuts the sector into a grid of small logical towers. For every tower the block finds the one pad in each layer that covers it. A tower fires when at least three of four layers agree in each group.

On each bunch-crossing strobe, the block records the lowest-numbered firing tower one clock later. It also raises a flag if more than one tower fired. Strip readout is limited to a single band, so a one-hot band select names the strip band (the tower row) that the downstream strip readout should read. All other strip bands stay idle.

Top module: `padco_trigger`

## Requirements
- R1: Pad hits arrive as `pad_hits_i`, with layer L occupying bits L*9 to L*9+8 and pad (px,py) at bit offset py*3+px. Layers 0..3 form group 0 and layers 4..7 form group 1. For a layer with position k (0..3) in its group, tower (tx,ty) maps to px=(tx+k[0])>>1 and py=(ty+k[1])>>1.
- R2: A group supports a tower only when at least 3 of its 4 layers have the mapped pad hit. Two hits are not enough.
- R3: A tower fires only when both groups support it. Four hits in one group with two in the other do not fire.
- R4: Towers are numbered ty*4+tx. When towers fire, `tower_idx_o` reports the lowest-numbered one.
- R5: `multi_o` is high together with `valid_o` exactly when two or more towers fired in that crossing.
- R6: `band_sel_o` is one-hot with bit ty of the reported tower set while `valid_o` is high. It is all zero otherwise.
- R7: A decision is taken on a clock edge where `bx_strobe_i` is high and appears on the outputs after that edge. `valid_o` is a one-cycle pulse per strobe. Pad hits present without a strobe have no effect.
- R8: `tower_idx_o` holds its value between strobes. It becomes 0 after a strobe in which no tower fired.
- R9: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bx_strobe_i | input | 1 | Bunch-crossing strobe; hits are evaluated on this cycle |
| pad_hits_i | input | 72 | Pad hit bits, 9 per layer, 8 layers |
| valid_o | output | 1 | One-cycle pulse: a tower fired |
| tower_idx_o | output | 4 | Lowest firing tower, ty*4+tx |
| multi_o | output | 1 | More than one tower fired |
| band_sel_o | output | 4 | One-hot strip band (tower row) select |

## Verification
The assertions assume that `bx_strobe_i` is a clean synchronous level, sampled once per edge, and that `rst_ni` is released away from the clock edge. The bench drives every input on the falling edge and holds the strobe for exactly one cycle, then drops it. Between strobes it changes the pad hits to random values, which tests the claim that those hits are ignored. Random patterns seldom form a coincidence by chance. For that reason most trials plant a tower with a random subset of layers per group on top of sparse noise. This covers group counts of 2, 3 and 4 as well as overlapping candidates.

// File: rtl/padco_pkg.sv
package padco_pkg;
  // pad covering tower (tx,ty) in a layer at position k of its group
  function automatic int pad_index(input int tx, input int ty, input int k, input int pad_x);
    int px;
    int py;
    px = (tx + (k & 1)) >> 1;
    py = (ty + ((k >> 1) & 1)) >> 1;
    return py * pad_x + px;
  endfunction
endpackage

// File: rtl/padco_layer_map.sv
module padco_layer_map #(
  parameter int TWR_X = 4,
  parameter int TWR_Y = 4,
  parameter int POS   = 0,
  localparam int PAD_X = TWR_X / 2 + 1,
  localparam int PAD_Y = TWR_Y / 2 + 1,
  localparam int PADS  = PAD_X * PAD_Y,
  localparam int N_TWR = TWR_X * TWR_Y
) (
  input  logic [PADS-1:0]  pads_i,
  output logic [N_TWR-1:0] twr_hit_o
);
  for (genvar ty = 0; ty < TWR_Y; ty++) begin : g_row
    for (genvar tx = 0; tx < TWR_X; tx++) begin : g_col
      localparam int PI = padco_pkg::pad_index(tx, ty, POS, PAD_X);
      assign twr_hit_o[ty*TWR_X+tx] = pads_i[PI];
    end
  end
endmodule

// File: rtl/padco_quad_vote.sv
module padco_quad_vote #(
  parameter int N_TWR    = 16,
  parameter int N_LYR    = 4,
  parameter int MAJORITY = 3,
  localparam int CNT_W   = $clog2(N_LYR + 1)
) (
  input  logic [N_LYR*N_TWR-1:0] lyr_hit_i,
  output logic [N_TWR-1:0]       ok_o
);
  for (genvar t = 0; t < N_TWR; t++) begin : g_twr
    logic [CNT_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int l = 0; l < N_LYR; l++)
        cnt = cnt + CNT_W'(lyr_hit_i[l*N_TWR+t]);
    end
    assign ok_o[t] = (int'(cnt) >= MAJORITY);
  end
endmodule

// File: rtl/padco_pick.sv
module padco_pick #(
  parameter int TWR_X = 4,
  parameter int TWR_Y = 4,
  localparam int N_TWR = TWR_X * TWR_Y,
  localparam int TWR_W = $clog2(N_TWR)
) (
  input  logic [N_TWR-1:0] fire_i,
  output logic             any_o,
  output logic             multi_o,
  output logic [TWR_W-1:0] idx_o,
  output logic [TWR_Y-1:0] band_o
);
  always_comb begin
    idx_o = '0;
    for (int t = N_TWR - 1; t >= 0; t--)
      if (fire_i[t]) idx_o = TWR_W'(t);
  end

  assign any_o   = |fire_i;
  assign multi_o = |(fire_i & (fire_i - N_TWR'(1)));

  // row of the winner selects the strip band
  for (genvar r = 0; r < TWR_Y; r++) begin : g_band
    assign band_o[r] = any_o && (int'(idx_o) / TWR_X == r);
  end
endmodule

// File: rtl/padco_trigger.sv
module padco_trigger #(
  parameter int TWR_X      = 4,
  parameter int TWR_Y      = 4,
  parameter int N_QUAD     = 2,
  parameter int LYR_PER_Q  = 4,
  parameter int MAJORITY   = 3,
  localparam int N_LAYER   = N_QUAD * LYR_PER_Q,
  localparam int PAD_X     = TWR_X / 2 + 1,
  localparam int PAD_Y     = TWR_Y / 2 + 1,
  localparam int PADS      = PAD_X * PAD_Y,
  localparam int N_TWR     = TWR_X * TWR_Y,
  localparam int TWR_W     = $clog2(N_TWR)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bx_strobe_i,
  input  logic [N_LAYER*PADS-1:0] pad_hits_i,
  output logic                    valid_o,
  output logic [TWR_W-1:0]        tower_idx_o,
  output logic                    multi_o,
  output logic [TWR_Y-1:0]        band_sel_o
);
  logic [N_QUAD-1:0][N_TWR-1:0] quad_ok;
  logic [N_TWR-1:0]             fire;

  for (genvar q = 0; q < N_QUAD; q++) begin : g_quad
    logic [LYR_PER_Q*N_TWR-1:0] lyr_hit;
    for (genvar k = 0; k < LYR_PER_Q; k++) begin : g_lyr
      padco_layer_map #(
        .TWR_X(TWR_X), .TWR_Y(TWR_Y), .POS(k)
      ) i_map (
        .pads_i   (pad_hits_i[(q*LYR_PER_Q+k)*PADS +: PADS]),
        .twr_hit_o(lyr_hit[k*N_TWR +: N_TWR])
      );
    end
    padco_quad_vote #(
      .N_TWR(N_TWR), .N_LYR(LYR_PER_Q), .MAJORITY(MAJORITY)
    ) i_vote (
      .lyr_hit_i(lyr_hit),
      .ok_o     (quad_ok[q])
    );
  end

  always_comb begin
    fire = '1;
    for (int q = 0; q < N_QUAD; q++) fire = fire & quad_ok[q];
  end

  logic             any_d, multi_d;
  logic [TWR_W-1:0] idx_d;
  logic [TWR_Y-1:0] band_d;

  padco_pick #(.TWR_X(TWR_X), .TWR_Y(TWR_Y)) i_pick (
    .fire_i (fire),
    .any_o  (any_d),
    .multi_o(multi_d),
    .idx_o  (idx_d),
    .band_o (band_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      multi_o     <= 1'b0;
      tower_idx_o <= '0;
      band_sel_o  <= '0;
    end else if (bx_strobe_i) begin
      valid_o     <= any_d;
      multi_o     <= multi_d;
      tower_idx_o <= idx_d;
      band_sel_o  <= band_d;
    end else begin
      valid_o    <= 1'b0;
      multi_o    <= 1'b0;
      band_sel_o <= '0;
    end
  end
endmodule

// File: rtl/padco_chk.sv
module padco_chk #(
  parameter int TWR_X = 4,
  parameter int TWR_Y = 4,
  localparam int N_TWR = TWR_X * TWR_Y,
  localparam int TWR_W = $clog2(N_TWR)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bx_strobe_i,
  input logic             valid_o,
  input logic [TWR_W-1:0] tower_idx_o,
  input logic             multi_o,
  input logic [TWR_Y-1:0] band_sel_o
);
  // R7
  valid_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bx_strobe_i));
  // R7
  no_strobe_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bx_strobe_i |=> !valid_o);
  // R5
  multi_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> valid_o);
  // R6
  band_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(band_sel_o) == 1 && band_sel_o[int'(tower_idx_o) / TWR_X]));
  // R6
  band_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> band_sel_o == '0);
  // R8
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bx_strobe_i |=> $stable(tower_idx_o));
  // R9
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !multi_o && tower_idx_o == '0 && band_sel_o == '0));
endmodule

bind padco_trigger padco_chk #(.TWR_X(TWR_X), .TWR_Y(TWR_Y)) i_padco_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bx_strobe_i(bx_strobe_i),
  .valid_o    (valid_o),
  .tower_idx_o(tower_idx_o),
  .multi_o    (multi_o),
  .band_sel_o (band_sel_o)
);

// File: tb/test_padco_trigger.sv
`timescale 1ns/1ps
module test_padco_trigger;
  localparam int NL = 8;
  localparam int PP = 9;
  localparam int HW = NL * PP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strobe = 1'b0;
  logic [HW-1:0] hits = '0;
  logic          valid, multi;
  logic [3:0]    idx;
  logic [3:0]    band;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  padco_trigger i_padco_trigger (
    .clk_i(clk), .rst_ni(rst_n), .bx_strobe_i(strobe), .pad_hits_i(hits),
    .valid_o(valid), .tower_idx_o(idx), .multi_o(multi), .band_sel_o(band)
  );

  function automatic int bitpos(int layer, int tx, int ty);
    int k = layer % 4;
    int px = (tx + (k & 1)) >> 1;
    int py = (ty + ((k >> 1) & 1)) >> 1;
    return layer * PP + py * 3 + px;
  endfunction

  function automatic logic [15:0] model_fire(logic [HW-1:0] h);
    logic [15:0] f = '0;
    for (int t = 0; t < 16; t++) begin
      int c0 = 0;
      int c1 = 0;
      for (int l = 0; l < 4; l++) c0 += h[bitpos(l, t % 4, t / 4)];
      for (int l = 4; l < 8; l++) c1 += h[bitpos(l, t % 4, t / 4)];
      f[t] = (c0 >= 3) && (c1 >= 3);
    end
    return f;
  endfunction

  function automatic logic [HW-1:0] plant(logic [HW-1:0] h, int t, logic [7:0] lmask);
    for (int l = 0; l < NL; l++)
      if (lmask[l]) h[bitpos(l, t % 4, t / 4)] = 1'b1;
    return h;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int last_idx = 0;

  // one crossing: apply, check decision, then drop strobe with junk hits and check idle
  task automatic crossing(logic [HW-1:0] h);
    logic [15:0] f = model_fire(h);
    int e_idx = 0;
    int e_valid = (f != 0);
    for (int t = 15; t >= 0; t--) if (f[t]) e_idx = t;
    @(negedge clk);
    hits = h; strobe = 1'b1;
    @(negedge clk);
    chk("R3 valid", valid, e_valid);
    chk("R4 tower", idx, e_idx);
    chk("R5 multi", multi, ($countones(f) > 1) ? 1 : 0);
    chk("R6 band", band, e_valid ? (1 << (e_idx / 4)) : 0);
    last_idx = e_idx;
    strobe = 1'b0;
    hits = {$urandom, $urandom, $urandom};
    @(negedge clk);
    chk("R7 pulse", valid, 0);
    chk("R7 no multi", multi, 0);
    chk("R6 band idle", band, 0);
    chk("R8 hold", idx, last_idx);
  endtask

  initial begin
    logic [HW-1:0] h;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R9 valid", valid, 0);
    chk("R9 tower", idx, 0);
    chk("R9 multi", multi, 0);
    chk("R9 band", band, 0);
    rst_n = 1'b1;

    // R1 R4 single tower, all layers
    crossing(plant('0, 6, 8'hFF));
    // R2 3+3 fires
    crossing(plant('0, 9, 8'b1011_0111));
    // R2 2 in group 0 fails
    crossing(plant('0, 9, 8'b1111_0011));
    // R3 2 in group 1 fails
    crossing(plant('0, 5, 8'b0101_1111));
    // R4 R5 two towers, lowest wins
    crossing(plant(plant('0, 14, 8'hFF), 3, 8'hFF));
    // corners
    crossing(plant('0, 15, 8'hFF));
    crossing(plant('0, 0, 8'b1110_1101));
    // everything hit
    crossing('1);
    // empty crossing sets index to 0
    crossing(plant('0, 10, 8'hFF));
    crossing('0);
    // R7 hits without strobe ignored: explicit
    @(negedge clk);
    hits = plant('0, 12, 8'hFF); strobe = 1'b0;
    @(negedge clk);
    chk("R7 ignored valid", valid, 0);
    chk("R7 ignored idx", idx, 0);

    // R1 each tower via single-pad mapping
    for (int t = 0; t < 16; t++) crossing(plant('0, t, 8'hFF));

    for (int n = 0; n < 400; n++) begin
      h = '0;
      for (int b = 0; b < HW; b++) h[b] = ($urandom_range(15) == 0);
      if ($urandom_range(2) != 0) begin
        logic [7:0] m;
        for (int l = 0; l < 8; l++) m[l] = ($urandom_range(3) != 0);
        h = plant(h, $urandom_range(15), m);
      end
      crossing(h);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule